// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART receiver's deserializer and the host read port. Each completed character is offered as a one-cycle strobe. The strobe carries the data byte, a ninth data bit and a framing-error flag. The block queues the character in a small circular FIFO of `DEPTH` entries (default two).

Every entry carries its own status beside its data, so the status outputs always describe the character at the head of the queue. The host inspects the status first and then pops the entry with a one-cycle data-read strobe. After that read, the popped entry's status is gone.

When the FIFO is full, a newly completed character is not lost. It stays in a hold stage that stands in for the receiver shift register. It is committed to the FIFO as soon as a slot frees. It is thrown away only if the receiver reports a new start bit while the FIFO is still full. That discard is remembered and is reported through the overrun flag of the next character that is queued. All head outputs and the receive-complete flag are registered and change on the clock edge that ends the cycle in which the causing input was high.

Top module: `uart_rx_buffer`

## Requirements
- R1: Characters leave the buffer in the order they were completed, and `rx_done` is high exactly when at least one entry is queued.
- R2: Each cycle with `rd_data` high and a non-empty queue removes exactly one entry. A read of an empty queue changes nothing.
- R3: The head outputs `head_data`, `head_bit9`, `head_ferr` and `head_ovr` show the fields stored with the oldest entry. After a pop they show the next entry's own fields. With the queue empty, all of them read 0.
- R4: A character completed while the queue is full goes to the hold stage and `hold_busy` becomes 1 on the next edge. This also holds when a read occurs in the same cycle.
- R5: Once a slot is free at a clock edge, the held character enters the queue at the following edge and `hold_busy` returns to 0. It is later read out after the entries ahead of it.
- R6: A `start_det` pulse while the hold stage is busy and the queue is full discards the held character and clears `hold_busy`. A read in that same cycle does not save it.
- R7: After such a discard, the next character written into the queue carries `head_ovr` = 1. Characters already queued and later characters carry 0.
- R8: A `start_det` pulse while the hold stage is empty changes no output and records no overrun.
- R9: A cycle with `rx_en` low empties the queue and the hold stage and forgets a pending overrun. While `rx_en` is low, characters and reads are ignored.
- R10: Under synchronous reset `rst`, `rx_done`, `hold_busy` and all head outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| char_valid | input | 1 | One-cycle strobe: a character has been completed |
| char_data | input | DATA_W | Data byte of the completed character |
| char_bit9 | input | 1 | Ninth data bit of the completed character |
| char_ferr | input | 1 | Framing error seen on the completed character |
| start_det | input | 1 | One-cycle strobe: the receiver saw a new start bit |
| rd_data | input | 1 | Host data read; pops the head entry |
| head_data | output | DATA_W | Data byte of the head entry |
| head_bit9 | output | 1 | Ninth bit of the head entry |
| head_ferr | output | 1 | Framing-error flag of the head entry |
| head_ovr | output | 1 | Data was lost just before the head entry |
| rx_done | output | 1 | Queue holds at least one entry |
| hold_busy | output | 1 | A character is parked in the hold stage |

## Verification
The bench fills the queue and parks a third character. It then pops one entry and checks that the parked character stays in the hold stage for exactly one more edge before it enters the queue. An off-by-one in this release rule shows up as `hold_busy` changing one edge early or late.

It issues a start bit against a full queue with a parked character. It then checks that the overrun flag appears on the first character queued afterwards and on no other entry. A design that flags the wrong entry, or keeps the flag set, fails these checks.

A character arriving in the same cycle as a read of a full queue must still be parked rather than written over a live slot. A flush must also drop a pending overrun. A design that only clears the queue on a flush would report a false overrun afterwards.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  // Layout of one stored entry: status flags in the low bits, data above.
  localparam int FLD_OVR  = 0;
  localparam int FLD_FERR = 1;
  localparam int FLD_BIT9 = 2;
  localparam int FLD_DATA = 3;

  // Which source feeds the queue write port in a given cycle.
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_LIVE = 2'd1,
    WSRC_HOLD = 2'd2
  } wsrc_e;

endpackage

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
  import rxbuf_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         char_valid,
  input  logic [W-1:0] char_word,
  input  logic         start_det,
  input  logic         fifo_full,
  input  logic         wr_fire,
  output logic         hold_v,
  output logic [W-1:0] hold_word,
  output logic         release_now,
  output logic         ovr_pend
);

  logic capture;
  logic drop;

  assign capture     = en && char_valid && fifo_full && !hold_v;
  assign release_now = en && hold_v && !fifo_full;
  assign drop        = en && hold_v && fifo_full && start_det;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_v <= 1'b0;
    end else if (capture) begin
      hold_v <= 1'b1;
    end else if (release_now || drop) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      hold_word <= char_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ovr_pend <= 1'b0;
    end else if (drop) begin
      ovr_pend <= 1'b1;
    end else if (wr_fire) begin
      ovr_pend <= 1'b0;
    end
  end

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (en && char_valid && fifo_full) |=> hold_v); // R4

  AST_NO_LIVE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    (en && char_valid) |-> !hold_v); // R4

  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (en && hold_v && !fifo_full) |=> !hold_v); // R5

  AST_DROP_ON_START: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_v) && !hold_v && $past(en) && $past(fifo_full)) |-> $past(start_det)); // R6

endmodule

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
  import rxbuf_pkg::*;
#(
  parameter int W     = 11,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_req,
  output logic         full,
  output logic         nonempty_q,
  output logic [W-1:0] head_q
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
  logic [CW-1:0] count, count_nxt;
  logic          wr_fire, rd_fire;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_MAX);
  assign wr_fire = wr_en && !flush;
  assign rd_fire = rd_req && !flush && (count != '0);

  always_comb begin
    wptr_nxt  = wr_fire ? ptr_inc(wptr) : wptr;
    rptr_nxt  = rd_fire ? ptr_inc(rptr) : rptr;
    count_nxt = count;
    if (wr_fire && !rd_fire) begin
      count_nxt = count + 1'b1;
    end else if (!wr_fire && rd_fire) begin
      count_nxt = count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nxt;
      rptr  <= rptr_nxt;
      count <= count_nxt;
    end
  end

  // Storage without reset so it can map to distributed or block RAM.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[wptr] <= wr_word;
    end
  end

  // Registered head with forwarding of a same-cycle write to the new head slot.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q     <= '0;
      nonempty_q <= 1'b0;
    end else begin
      nonempty_q <= (count_nxt != '0);
      if (count_nxt == '0) begin
        head_q <= '0;
      end else if (wr_fire && (wptr == rptr_nxt)) begin
        head_q <= wr_word;
      end else begin
        head_q <= mem[rptr_nxt];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CNT_MAX)); // R4

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && !wr_fire) |=> (count == $past(count) - 1'b1)); // R2

  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!flush && !wr_en && count == '0) |=> (count == '0)); // R2

  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    nonempty_q == (count != '0)); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!nonempty_q && count == '0)); // R9

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_bit9,
  input  logic              char_ferr,
  input  logic              start_det,
  input  logic              rd_data,
  output logic [DATA_W-1:0] head_data,
  output logic              head_bit9,
  output logic              head_ferr,
  output logic              head_ovr,
  output logic              rx_done,
  output logic              hold_busy
);

  localparam int ENTRY_W = DATA_W + FLD_DATA;

  logic [ENTRY_W-1:0] live_word, hold_word, wr_word, head_word;
  logic               fifo_full, hold_v, hold_release, ovr_pend, wr_en;
  wsrc_e              wsrc;

  assign live_word = {char_data, char_bit9, char_ferr, 1'b0};

  // Held character has priority: a live one cannot arrive while it waits.
  always_comb begin
    wsrc = WSRC_NONE;
    if (rx_en) begin
      if (hold_release) begin
        wsrc = WSRC_HOLD;
      end else if (char_valid && !fifo_full) begin
        wsrc = WSRC_LIVE;
      end
    end
  end

  always_comb begin
    case (wsrc)
      WSRC_HOLD: wr_word = hold_word;
      WSRC_LIVE: wr_word = live_word;
      default:   wr_word = '0;
    endcase
    wr_word[FLD_OVR] = ovr_pend;
  end

  assign wr_en = (wsrc != WSRC_NONE);

  rxbuf_hold #(.W(ENTRY_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .en          (rx_en),
    .char_valid  (char_valid),
    .char_word   (live_word),
    .start_det   (start_det),
    .fifo_full   (fifo_full),
    .wr_fire     (wr_en),
    .hold_v      (hold_v),
    .hold_word   (hold_word),
    .release_now (hold_release),
    .ovr_pend    (ovr_pend)
  );

  rxbuf_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .flush      (!rx_en),
    .wr_en      (wr_en),
    .wr_word    (wr_word),
    .rd_req     (rd_data),
    .full       (fifo_full),
    .nonempty_q (rx_done),
    .head_q     (head_word)
  );

  assign head_data = head_word[FLD_DATA +: DATA_W];
  assign head_bit9 = head_word[FLD_BIT9];
  assign head_ferr = head_word[FLD_FERR];
  assign head_ovr  = head_word[FLD_OVR];
  assign hold_busy = hold_v;

  AST_OVR_ONCE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word[FLD_OVR]) |=> !ovr_pend); // R7

  AST_LIVE_QUEUED: assert property (@(posedge clk) disable iff (rst)
    (rx_en && char_valid && !fifo_full) |=> rx_done); // R1

  AST_NO_START_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (rx_en && start_det && !hold_v && !ovr_pend) |=> !ovr_pend); // R8

endmodule

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst, rx_en, char_valid, char_bit9, char_ferr, start_det, rd_data;
  logic [DW-1:0] char_data;
  logic [DW-1:0] head_data;
  logic          head_bit9, head_ferr, head_ovr, rx_done, hold_busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_buffer #(.DATA_W(DW), .DEPTH(2)) uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .char_valid(char_valid),
    .char_data(char_data), .char_bit9(char_bit9), .char_ferr(char_ferr),
    .start_det(start_det), .rd_data(rd_data), .head_data(head_data),
    .head_bit9(head_bit9), .head_ferr(head_ferr), .head_ovr(head_ovr),
    .rx_done(rx_done), .hold_busy(hold_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic head_is(input string tag, input logic [DW-1:0] d, input logic b9,
                         input logic fe, input logic ov);
    chk({tag, " data"}, 32'(head_data), 32'(d));
    chk({tag, " bit9"}, 32'(head_bit9), 32'(b9));
    chk({tag, " ferr"}, 32'(head_ferr), 32'(fe));
    chk({tag, " ovr"},  32'(head_ovr),  32'(ov));
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d, input logic b9, input logic fe);
    char_valid = 1'b1; char_data = d; char_bit9 = b9; char_ferr = fe;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic pop();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  task automatic start_bit();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    chk("R10 rx_done", 32'(rx_done), 0);
    chk("R10 hold_busy", 32'(hold_busy), 0);
    head_is("R10 head", 8'h00, 0, 0, 0);
  endtask

  task automatic t_order_status();
    push(8'hA1, 1'b0, 1'b1);
    chk("R1 done after one", 32'(rx_done), 1);
    push(8'hB2, 1'b1, 1'b0);
    head_is("R3 first head", 8'hA1, 0, 1, 0);
    pop();
    head_is("R3 second head", 8'hB2, 1, 0, 0);
    chk("R1 still done", 32'(rx_done), 1);
    pop();
    chk("R2 empty after two reads", 32'(rx_done), 0);
    head_is("R3 empty head", 8'h00, 0, 0, 0);
  endtask

  task automatic t_empty_read();
    pop();
    chk("R2 empty read keeps empty", 32'(rx_done), 0);
    push(8'h5C, 1'b1, 1'b1);
    head_is("R2 after empty read", 8'h5C, 1, 1, 0);
    pop();
    chk("R2 single pop empties", 32'(rx_done), 0);
  endtask

  task automatic t_hold_release();
    push(8'h11, 0, 0);
    push(8'h22, 0, 0);
    chk("R4 no hold when room", 32'(hold_busy), 0);
    push(8'h33, 1, 0);
    chk("R4 third held", 32'(hold_busy), 1);
    head_is("R4 head unchanged", 8'h11, 0, 0, 0);
    pop();
    head_is("R5 head after pop", 8'h22, 0, 0, 0);
    chk("R5 hold still busy one edge", 32'(hold_busy), 1);
    cyc();
    chk("R5 hold released", 32'(hold_busy), 0);
    pop();
    head_is("R5 held char at head", 8'h33, 1, 0, 0);
    pop();
    chk("R5 drained", 32'(rx_done), 0);
  endtask

  task automatic t_read_with_arrival();
    push(8'h41, 0, 0);
    push(8'h42, 0, 0);
    rd_data = 1'b1; char_valid = 1'b1; char_data = 8'h43; char_bit9 = 0; char_ferr = 1;
    @(negedge clk);
    rd_data = 1'b0; char_valid = 1'b0;
    chk("R4 arrival with read parked", 32'(hold_busy), 1);
    head_is("R4 head after read", 8'h42, 0, 0, 0);
    cyc();
    chk("R5 parked char committed", 32'(hold_busy), 0);
    pop();
    head_is("R4 parked char intact", 8'h43, 0, 1, 0);
    pop();
    chk("R4 drained", 32'(rx_done), 0);
  endtask

  task automatic t_overrun();
    push(8'h61, 0, 0);
    push(8'h62, 0, 0);
    push(8'h63, 0, 0);
    start_bit();
    chk("R6 held char dropped", 32'(hold_busy), 0);
    head_is("R7 old head no ovr", 8'h61, 0, 0, 0);
    pop();
    head_is("R7 second no ovr", 8'h62, 0, 0, 0);
    cyc();
    chk("R6 dropped char never queued", 32'(hold_busy), 0);
    pop();
    chk("R6 only two remained", 32'(rx_done), 0);
    push(8'h64, 0, 0);
    head_is("R7 next char flagged", 8'h64, 0, 0, 1);
    pop();
    push(8'h65, 0, 0);
    head_is("R7 later char clear", 8'h65, 0, 0, 0);
    pop();
  endtask

  task automatic t_start_no_hold();
    push(8'h71, 0, 0);
    push(8'h72, 0, 0);
    start_bit();
    head_is("R8 head unchanged", 8'h71, 0, 0, 0);
    chk("R8 still done", 32'(rx_done), 1);
    chk("R8 no hold", 32'(hold_busy), 0);
    pop();
    pop();
    push(8'h73, 0, 0);
    head_is("R8 no overrun recorded", 8'h73, 0, 0, 0);
    pop();
  endtask

  task automatic t_disable();
    push(8'h81, 0, 1);
    push(8'h82, 1, 0);
    push(8'h83, 0, 0);
    start_bit();
    rx_en = 1'b0;
    cyc();
    chk("R9 flushed done", 32'(rx_done), 0);
    chk("R9 flushed hold", 32'(hold_busy), 0);
    head_is("R9 flushed head", 8'h00, 0, 0, 0);
    push(8'h84, 0, 0);
    chk("R9 ignored while disabled", 32'(rx_done), 0);
    rx_en = 1'b1;
    cyc();
    push(8'h85, 1, 1);
    head_is("R9 pending overrun forgotten", 8'h85, 1, 1, 0);
    pop();
    chk("R9 only new char queued", 32'(rx_done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst = 1'b1; rx_en = 1'b1; char_valid = 1'b0; char_data = '0;
    char_bit9 = 1'b0; char_ferr = 1'b0; start_det = 1'b0; rd_data = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    cyc();
    t_order_status();
    t_empty_read();
    t_hold_release();
    t_read_with_arrival();
    t_overrun();
    t_start_no_hold();
    t_disable();
    report();
  end

endmodule